// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the bit clock and the frame sync for a two-channel serial audio port when the port owns the clocks. A programmable divider derives the bit clock from the system clock, and a bit counter turns the bit clock into frames. Each frame is two words long. The sync is either one word wide (I2S mode) or one bit wide (DSP-A mode). A one-cycle frame-start strobe marks the first system clock cycle of every frame, so a serialiser can align its shift registers to it.

The divider ratio, word length and mode are taken from the inputs whenever the generator is idle and are frozen while it runs. Raising enable while master is set starts a frame on the next clock. Lowering enable lets the frame in progress finish, and then both clock outputs park low. When master is low the port's clocks come from outside, and this block stays idle.

Top module: `audio_fsync_gen`

## Requirements
- R1: While reset is held and after it is released, bclk, fsync and frame_start are low and the block is idle.
- R2: The bit clock period is R system clock cycles, with R = div_m1 + 1. It is high for the first ceil(R/2) cycles of each period, so for odd R the high phase is the longer one. A div_m1 of 0 is treated as R = 2.
- R3: A frame lasts 2 x word_len bit clock periods. frame_start is high for exactly the first system clock cycle of each frame, and that cycle is the first high cycle of the frame's first bit clock.
- R4: With mode_sel = 0 (I2S), fsync is high during the first word_len bit periods of every frame and low for the rest.
- R5: With mode_sel = 1 (DSP-A), fsync is high during the first bit period of every frame only.
- R6: With master = 0 the generator stays idle and all outputs stay low, whatever enable does.
- R7: When enable and master are both high in an idle cycle, bclk, fsync and frame_start all go high at the next clock edge.
- R8: When enable is low at the last cycle of a frame, the generator returns to idle at the next edge with all outputs low. Otherwise the next frame follows with no gap.
- R9: Changes to div_m1, word_len or mode_sel while the generator runs have no effect until it has stopped and been started again.
- R10: While running, fsync changes only on a clock edge where bclk rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, divided down to the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start request; when low, stop at the end of the frame |
| master | input | 1 | 1: this block drives the clocks; 0: it stays idle |
| mode_sel | input | 1 | 0: I2S (word-wide sync), 1: DSP-A (one-bit sync) |
| div_m1 | input | DIV_W | Bit clock divide ratio minus one |
| word_len | input | WL_W | Bits per word (1 or more) |
| bclk | output | 1 | Bit clock, registered |
| fsync | output | 1 | Frame sync, active high, registered |
| frame_start | output | 1 | One-cycle strobe on the first cycle of each frame |

## Verification
On every cycle, the assertions check these properties: outputs are parked while idle, a slave stays idle, the run flag drops only at a frame boundary with enable low, the counters stay in range, the configuration stays frozen during a run, and fsync moves only on a bit clock rise. The exact bit clock duty cycle, the sync width for each mode, the frame length and the strobe placement can only be shown by the bench's sweeps. The bench compares every output against an arithmetic schedule over a range of divide ratios, word lengths and both modes, and it changes the configuration in the middle of a run.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic {
    MODE_I2S = 1'b0,
    MODE_DSP = 1'b1
  } afs_mode_e;
endpackage

// File: rtl/afs_cfg_hold.sv
module afs_cfg_hold #(
  parameter int DIV_W = 8,
  parameter int WL_W  = 6,
  localparam int BW   = WL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [WL_W-1:0]  word_len,
  input  logic             mode_sel,
  output logic [DIV_W-1:0] rm1_o,
  output logic [DIV_W-1:0] half_o,
  output logic [BW-1:0]    per_m1_o,
  output logic [BW-1:0]    wid_o
);
  import afs_pkg::*;

  logic [DIV_W-1:0] rm1_l, half_l, rm1_q, half_q;
  logic [DIV_W:0]   half_wide;
  logic [BW-1:0]    per_l, wid_l, per_q, wid_q;
  afs_mode_e        mode_l;

  always_comb begin
    mode_l    = afs_mode_e'(mode_sel);
    rm1_l     = (div_m1 == '0) ? DIV_W'(1) : div_m1;
    half_wide = ({1'b0, rm1_l} + (DIV_W+1)'(2)) >> 1;
    half_l    = half_wide[DIV_W-1:0];
    per_l     = {word_len, 1'b0} - BW'(1);
    wid_l     = (mode_l == MODE_DSP) ? '0 : ({1'b0, word_len} - BW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rm1_q  <= DIV_W'(1);
      half_q <= DIV_W'(1);
      per_q  <= '0;
      wid_q  <= '0;
    end else if (!run) begin
      rm1_q  <= rm1_l;
      half_q <= half_l;
      per_q  <= per_l;
      wid_q  <= wid_l;
    end
  end

  assign rm1_o    = run ? rm1_q  : rm1_l;
  assign half_o   = run ? half_q : half_l;
  assign per_m1_o = run ? per_q  : per_l;
  assign wid_o    = run ? wid_q  : wid_l;

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(rm1_o) && $stable(per_m1_o) && $stable(wid_o)));
endmodule

// File: rtl/afs_bitdiv.sv
module afs_bitdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             run,
  input  logic [DIV_W-1:0] rm1,
  input  logic [DIV_W-1:0] half,
  output logic             bit_end,
  output logic             bclk
);
  logic [DIV_W-1:0] cnt, cnt_n;

  assign bit_end = run && (cnt == rm1);
  assign cnt_n   = bit_end ? '0 : cnt + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      bclk <= 1'b1;
    end else if (stop) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (run) begin
      cnt  <= cnt_n;
      bclk <= (cnt_n < half);
    end
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= rm1));
endmodule

// File: rtl/afs_framer.sv
module afs_framer #(
  parameter int WL_W = 6,
  localparam int BW  = WL_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          run,
  input  logic          bit_end,
  input  logic [BW-1:0] per_m1,
  input  logic [BW-1:0] wid,
  output logic          frame_end,
  output logic          fsync,
  output logic          frame_start
);
  logic [BW-1:0] bitn, bit_n;
  logic          last_bit;

  assign last_bit  = (bitn == per_m1);
  assign frame_end = run && bit_end && last_bit;
  assign bit_n     = last_bit ? '0 : bitn + BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitn        <= '0;
      fsync       <= 1'b0;
      frame_start <= 1'b0;
    end else if (start) begin
      bitn        <= '0;
      fsync       <= 1'b1;
      frame_start <= 1'b1;
    end else if (stop) begin
      bitn        <= '0;
      fsync       <= 1'b0;
      frame_start <= 1'b0;
    end else if (run && bit_end) begin
      bitn        <= bit_n;
      fsync       <= (bit_n <= wid);
      frame_start <= (bit_n == '0);
    end else begin
      frame_start <= 1'b0;
    end
  end

  a_r3_bit_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (bitn <= per_m1));
endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen #(
  parameter int DIV_W = 8,
  parameter int WL_W  = 6,
  localparam int BW   = WL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             master,
  input  logic             mode_sel,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [WL_W-1:0]  word_len,
  output logic             bclk,
  output logic             fsync,
  output logic             frame_start
);
  logic             run, start, stop, bit_end, frame_end;
  logic [DIV_W-1:0] rm1, half;
  logic [BW-1:0]    per_m1, wid;

  assign start = !run && enable && master;
  assign stop  = frame_end && !enable;

  always_ff @(posedge clk) begin
    if (rst)        run <= 1'b0;
    else if (start) run <= 1'b1;
    else if (stop)  run <= 1'b0;
  end

  afs_cfg_hold #(.DIV_W(DIV_W), .WL_W(WL_W)) u_cfg (
    .clk(clk), .rst(rst), .run(run), .div_m1(div_m1), .word_len(word_len),
    .mode_sel(mode_sel), .rm1_o(rm1), .half_o(half), .per_m1_o(per_m1), .wid_o(wid)
  );

  afs_bitdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .run(run),
    .rm1(rm1), .half(half), .bit_end(bit_end), .bclk(bclk)
  );

  afs_framer #(.WL_W(WL_W)) u_frm (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .run(run),
    .bit_end(bit_end), .per_m1(per_m1), .wid(wid), .frame_end(frame_end),
    .fsync(fsync), .frame_start(frame_start)
  );

  a_r1_idle_parked: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!bclk && !fsync && !frame_start));
  a_r6_slave_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !master) |=> !run);
  a_r8_stop_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end) |=> run);
  a_r3_strobe_aligned: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (bclk && fsync));
  a_r10_sync_on_rise: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (fsync != $past(fsync))) |-> (bclk && !$past(bclk)));
endmodule

// File: tb/audio_fsync_gen_bench.sv
module audio_fsync_gen_bench;
  localparam int DIV_W = 8;
  localparam int WL_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, master = 1'b0, mode_sel = 1'b0;
  logic [DIV_W-1:0] div_m1 = '0;
  logic [WL_W-1:0]  word_len = WL_W'(16);
  logic bclk, fsync, frame_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  audio_fsync_gen #(.DIV_W(DIV_W), .WL_W(WL_W)) u_audio_fsync_gen (
    .clk(clk), .rst(rst), .enable(enable), .master(master), .mode_sel(mode_sel),
    .div_m1(div_m1), .word_len(word_len), .bclk(bclk), .fsync(fsync),
    .frame_start(frame_start)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all_low(input string tag);
    chk(tag, "bclk", bclk, 1'b0);
    chk(tag, "fsync", fsync, 1'b0);
    chk(tag, "frame_start", frame_start, 1'b0);
  endtask

  // Run two frames with one configuration, change the inputs mid-run (R9),
  // drop enable during the second frame (R8) and check every cycle.
  task automatic run_case(input int d, input int wl, input bit dsp);
    int r, h, f, w, n, pert, stop_k, total;
    logic eb, ef, es;
    r = (d == 0) ? 2 : d + 1;
    h = (r + 1) / 2;
    f = 2 * wl;
    w = dsp ? 1 : wl;
    n = 2 * f * r;
    pert = 2 * r + 1;
    stop_k = f * r + 1;
    total = n + 3 * r;
    @(negedge clk);
    div_m1 = DIV_W'(d); word_len = WL_W'(wl); mode_sel = dsp; master = 1'b1;
    enable = 1'b1;
    chk_all_low("R7");
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k < n) begin
        eb = ((k % r) < h);
        ef = (((k / r) % f) < w);
        es = ((k % (r * f)) == 0);
      end else begin
        eb = 1'b0; ef = 1'b0; es = 1'b0;
      end
      if (k == 0) begin
        chk("R7", "bclk", bclk, 1'b1);
        chk("R7", "fsync", fsync, 1'b1);
        chk("R7", "frame_start", frame_start, 1'b1);
      end else if (k >= n) begin
        chk_all_low("R8");
      end else begin
        chk(k > pert ? "R9" : "R2", "bclk", bclk, eb);
        chk(dsp ? "R5" : "R4", "fsync", fsync, ef);
        chk("R3", "frame_start", frame_start, es);
      end
      if (k == pert) begin
        div_m1 = DIV_W'(d + 2); word_len = WL_W'(wl + 1); mode_sel = !dsp;
      end
      if (k == stop_k) enable = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all_low("R1");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_all_low("R1");

    // R6: slave mode keeps the generator idle with enable high
    master = 1'b0; enable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk_all_low("R6");
    end
    enable = 1'b0;
    @(negedge clk);

    foreach (int_dummy[i]) ;
    for (int di = 0; di < 5; di++) begin
      for (int wi = 0; wi < 4; wi++) begin
        for (int m = 0; m < 2; m++) begin
          int dv, wv;
          dv = (di == 4) ? 6 : di;
          wv = (wi == 0) ? 1 : (wi == 1) ? 2 : (wi == 2) ? 5 : 16;
          run_case(dv, wv, m[0]);
        end
      end
    end

    // R8 continuity and R9 new config used after restart: a standard 16-bit case
    run_case(3, 16, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  int int_dummy[1];

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule